// File: doc/BRIEF.md
# Parallel Concatenated Turbo Encoder

This block encodes one code block of K information bits into three aligned output streams: the systematic bits, the parity of a recursive 8-state convolutional encoder that sees the bits in natural order, and the parity of an identical encoder that sees them in permuted order. The block length K and the two permutation coefficients are sampled with a start pulse. The K input bits are then accepted one per handshake into an internal bit buffer.

Once the whole block is stored, one output beat is emitted per accepted handshake. Beat k carries systematic bit k, natural-order parity k and permuted-order parity k. The permuted read address is pi(k) = (f1*k + f2*k*k) mod K. It is produced incrementally with additions and conditional subtractions only. After the K data beats, four flagged tail beats carry the 12 termination bits that return both encoders to the zero state. A done pulse closes the block.

Top module: `pcc_turbo_enc`

## Requirements
- R1: After reset, in_ready, out_valid, out_tail and done are all 0.
- R2: After an accepted start, in_ready stays 1 until exactly K bits (K = blk_len) have been accepted, and is 0 in the cycle after the K-th. in_ready and out_valid are never 1 together.
- R3: Each block produces exactly K+4 accepted output beats. done is 1 for exactly one cycle, in the cycle after the last beat is accepted.
- R4: out_sys on data beat k equals the k-th accepted input bit.
- R5: out_par1 on data beat k is the parity of a recursive encoder that starts from the zero state and is fed the input bits in natural order. Its state is (s1,s2,s3), with s1 the newest. For input u, the feedback is a = u^s2^s3 and the parity is a^s1^s3, which gives feedback polynomial 1+D^2+D^3 and feedforward polynomial 1+D+D^3. The next state is (a,s1,s2).
- R6: out_par2 on data beat k is the parity of an identical zero-started encoder fed input bit pi(k), where pi(k) = (f1*k + f2*k*k) mod K, with f1 = coef_f1, f2 = coef_f2 and both coefficients below K.
- R7: The four tail beats have out_tail = 1. They carry 12 bits, three per beat in the order out_sys, out_par1, out_par2. These are x,z,x,z,x,z of the natural encoder followed by x,z,x,z,x,z of the permuted encoder. Each (x,z) pair is one termination step, in which x = s2^s3 is fed so that a = 0, and z is the parity produced by that step.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and all output bits hold on the next cycle.
- R9: A start pulse while a block is being loaded or emitted is ignored. The current stream continues unchanged and in_ready stays 0 during emission.
- R10: Block lengths from 40 up to 6144 are supported, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block when idle; samples the length and coefficients |
| blk_len | input | 13 | Block length K |
| coef_f1 | input | 13 | Linear permutation coefficient, below K |
| coef_f2 | input | 13 | Quadratic permutation coefficient, below K |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block accepts an input bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sys | output | 1 | Systematic bit or tail bit |
| out_par1 | output | 1 | Natural-order parity or tail bit |
| out_par2 | output | 1 | Permuted-order parity or tail bit |
| out_tail | output | 1 | Beat belongs to the termination tail |
| done | output | 1 | One-cycle pulse after the final tail beat |

## Verification
If either encoder's state register is corrupted, the parity stream diverges on the very next data beat. The error also persists through every later beat and the tail, because the recursion carries it forward. A faulty permutation recurrence shows up in out_par2 only, typically within the first few beats, since the step delta changes every beat. Length or counter faults appear as a misplaced out_tail flag or a mistimed done, both of which the scoreboard compares beat by beat under random backpressure.

// File: rtl/turbo_pkg.sv
package turbo_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_CODE,
        PH_TAIL
    } phase_e;

    // st[0] is the newest register, st[2] the oldest.
    // Result bit order: x0, z0, x1, z1, x2, z2 (bit 0 first).
    function automatic logic [5:0] term_bits(input logic [2:0] st);
        logic [5:0] t;
        t[0] = st[1] ^ st[2];
        t[1] = st[0] ^ st[2];
        t[2] = st[0] ^ st[1];
        t[3] = st[1];
        t[4] = st[0];
        t[5] = st[0];
        return t;
    endfunction

endpackage

// File: rtl/rsc_encoder.sv
module rsc_encoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       u,
    output logic       par,
    output logic [2:0] st
);
    logic [2:0] st_d, st_q;
    logic       fb;

    always_comb begin
        fb   = u ^ st_q[1] ^ st_q[2];
        par  = fb ^ st_q[0] ^ st_q[2];
        st_d = st_q;
        if (clr)
            st_d = '0;
        else if (en)
            st_d = {st_q[1], st_q[0], fb};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/qpp_index_gen.sv
module qpp_index_gen #(
    parameter int KW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    input  logic [KW-1:0] blk_len,
    input  logic [KW-1:0] f1,
    input  logic [KW-1:0] f2,
    output logic [KW-1:0] idx
);
    typedef struct packed {
        logic [KW-1:0] pi;
        logic [KW-1:0] delta;
        logic [KW-1:0] inc;
        logic [KW-1:0] k;
    } qpp_t;

    qpp_t q_d, q_q;

    function automatic logic [KW-1:0] add_mod(input logic [KW-1:0] a,
                                              input logic [KW-1:0] b,
                                              input logic [KW-1:0] m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[KW-1:0];
    endfunction

    always_comb begin
        q_d = q_q;
        if (init) begin
            q_d.k     = blk_len;
            q_d.pi    = '0;
            q_d.delta = add_mod(f1, f2, blk_len);
            q_d.inc   = add_mod(f2, f2, blk_len);
        end else if (step) begin
            q_d.pi    = add_mod(q_q.pi, q_q.delta, q_q.k);
            q_d.delta = add_mod(q_q.delta, q_q.inc, q_q.k);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign idx = q_q.pi;
endmodule

// File: rtl/bit_buffer.sv
module bit_buffer #(
    parameter int DEPTH  = 6144,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic              rd_bit_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic              rd_bit_b
);
    localparam int WORDS = (DEPTH + WORD_W - 1) / WORD_W;
    localparam int LW    = $clog2(WORD_W);

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr[ADDR_W-1:LW]][wr_addr[LW-1:0]] <= wr_bit;
    end

    always_comb begin
        rd_bit_a = mem[rd_addr_a[ADDR_W-1:LW]][rd_addr_a[LW-1:0]];
        rd_bit_b = mem[rd_addr_b[ADDR_W-1:LW]][rd_addr_b[LW-1:0]];
    end
endmodule

// File: rtl/pcc_turbo_enc.sv
module pcc_turbo_enc #(
    parameter int K_MAX  = 6144,
    parameter int WORD_W = 32,
    parameter int KW     = $clog2(K_MAX + 1),
    parameter int N_ENC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] blk_len,
    input  logic [KW-1:0] coef_f1,
    input  logic [KW-1:0] coef_f2,
    input  logic          in_valid,
    input  logic          in_bit,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sys,
    output logic          out_par1,
    output logic          out_par2,
    output logic          out_tail,
    output logic          done
);
    import turbo_pkg::*;

    localparam int TAIL_BEATS = 4;
    localparam int TAIL_BITS  = 6 * N_ENC;

    typedef struct packed {
        phase_e        phase;
        logic [KW-1:0] cnt;
        logic [KW-1:0] k;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          take_start, take_bit, beat_fire, code_fire;
    logic          bit_nat, bit_perm;
    logic [KW-1:0] perm_idx;
    logic [N_ENC-1:0]     enc_u, enc_par;
    logic [2:0]           enc_st [N_ENC];
    logic [TAIL_BITS-1:0] tail_vec;
    logic [2:0]           tail_beat;

    assign take_start = (ctl_q.phase == PH_IDLE) && start;
    assign in_ready   = (ctl_q.phase == PH_LOAD);
    assign take_bit   = in_ready && in_valid;
    assign out_valid  = (ctl_q.phase == PH_CODE) || (ctl_q.phase == PH_TAIL);
    assign out_tail   = (ctl_q.phase == PH_TAIL);
    assign beat_fire  = out_valid && out_ready;
    assign code_fire  = beat_fire && (ctl_q.phase == PH_CODE);
    assign done       = ctl_q.done;

    bit_buffer #(
        .DEPTH (K_MAX),
        .WORD_W(WORD_W),
        .ADDR_W(KW)
    ) u_buf (
        .clk      (clk),
        .wr_en    (take_bit),
        .wr_addr  (ctl_q.cnt),
        .wr_bit   (in_bit),
        .rd_addr_a(ctl_q.cnt),
        .rd_bit_a (bit_nat),
        .rd_addr_b(perm_idx),
        .rd_bit_b (bit_perm)
    );

    qpp_index_gen #(.KW(KW)) u_qpp (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (take_start),
        .step   (code_fire),
        .blk_len(blk_len),
        .f1     (coef_f1),
        .f2     (coef_f2),
        .idx    (perm_idx)
    );

    assign enc_u[0] = bit_nat;
    assign enc_u[1] = bit_perm;

    for (genvar e = 0; e < N_ENC; e++) begin : g_enc
        rsc_encoder u_rsc (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (take_start),
            .en   (code_fire),
            .u    (enc_u[e]),
            .par  (enc_par[e]),
            .st   (enc_st[e])
        );
        assign tail_vec[6*e +: 6] = term_bits(enc_st[e]);
    end

    always_comb begin
        unique case (ctl_q.cnt[1:0])
            2'd0:    tail_beat = tail_vec[2:0];
            2'd1:    tail_beat = tail_vec[5:3];
            2'd2:    tail_beat = tail_vec[8:6];
            default: tail_beat = tail_vec[11:9];
        endcase
    end

    always_comb begin
        if (ctl_q.phase == PH_TAIL) begin
            out_sys  = tail_beat[0];
            out_par1 = tail_beat[1];
            out_par2 = tail_beat[2];
        end else if (ctl_q.phase == PH_CODE) begin
            out_sys  = bit_nat;
            out_par1 = enc_par[0];
            out_par2 = enc_par[1];
        end else begin
            out_sys  = 1'b0;
            out_par1 = 1'b0;
            out_par2 = 1'b0;
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.phase = PH_LOAD;
                    ctl_d.cnt   = '0;
                    ctl_d.k     = blk_len;
                end
            end
            PH_LOAD: begin
                if (in_valid) begin
                    if (ctl_q.cnt == ctl_q.k - KW'(1)) begin
                        ctl_d.phase = PH_CODE;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + KW'(1);
                    end
                end
            end
            PH_CODE: begin
                if (out_ready) begin
                    if (ctl_q.cnt == ctl_q.k - KW'(1)) begin
                        ctl_d.phase = PH_TAIL;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + KW'(1);
                    end
                end
            end
            default: begin
                if (out_ready) begin
                    if (ctl_q.cnt == KW'(TAIL_BEATS - 1)) begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.cnt   = '0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + KW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.k     <= '0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/turbo_enc_chk.sv
module turbo_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_sys,
    input logic out_par1,
    input logic out_par2,
    input logic out_tail,
    input logic done
);
    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable({out_sys, out_par1, out_par2, out_tail})));

    assert_phase_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_done_after_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && out_tail));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_tail_is_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_tail |-> out_valid);
endmodule

bind pcc_turbo_enc turbo_enc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_sys  (out_sys),
    .out_par1 (out_par1),
    .out_par2 (out_par2),
    .out_tail (out_tail),
    .done     (done)
);

// File: tb/sim_pcc_turbo_enc.sv
module sim_pcc_turbo_enc;
    localparam int KW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] blk_len = '0, coef_f1 = '0, coef_f2 = '0;
    logic          in_valid = 1'b0, in_bit = 1'b0, in_ready;
    logic          out_valid, out_ready = 1'b0;
    logic          out_sys, out_par1, out_par2, out_tail, done;

    int n_tests = 0;
    int n_fail  = 0;
    int blocks_done = 0;
    logic [3:0] exp_q [$];   // {tail, sys, par1, par2}
    bit  ubits [6144];

    always #10 clk = ~clk;

    pcc_turbo_enc u0 (.*);

    function automatic void note(input bit ok, input string req, input string what,
                                 input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    // Build expected beats from the requirements (R4..R7)
    task automatic build_expected(input int k, input int f1, input int f2);
        int a1 = 0, b1 = 0, c1 = 0, a2 = 0, b2 = 0, c2 = 0;
        bit tl [12];
        for (int i = 0; i < k; i++) begin
            int pi;
            bit x, y, fa, fb, z1, z2;
            pi = int'((longint'(f1) * i + longint'(f2) * i * i) % k);
            x = ubits[i];
            y = ubits[pi];
            fa = x ^ b1[0] ^ c1[0];  z1 = fa ^ a1[0] ^ c1[0];
            c1 = b1; b1 = a1; a1 = fa;
            fb = y ^ b2[0] ^ c2[0];  z2 = fb ^ a2[0] ^ c2[0];
            c2 = b2; b2 = a2; a2 = fb;
            exp_q.push_back({1'b0, x, z1, z2});
        end
        for (int s = 0; s < 3; s++) begin
            bit x, z;
            x = b1[0] ^ c1[0]; z = a1[0] ^ c1[0];
            tl[2*s] = x; tl[2*s+1] = z;
            c1 = b1; b1 = a1; a1 = 0;
        end
        for (int s = 0; s < 3; s++) begin
            bit x, z;
            x = b2[0] ^ c2[0]; z = a2[0] ^ c2[0];
            tl[6+2*s] = x; tl[6+2*s+1] = z;
            c2 = b2; b2 = a2; a2 = 0;
        end
        for (int j = 0; j < 4; j++)
            exp_q.push_back({1'b1, tl[3*j], tl[3*j+1], tl[3*j+2]});
    endtask

    task automatic run_block(input int k, input int f1, input int f2, input bit poke_start);
        int target;
        target = blocks_done + 1;
        for (int i = 0; i < k; i++) ubits[i] = 1'($urandom);
        build_expected(k, f1, f2);
        @(posedge clk); #2;
        start = 1'b1; blk_len = KW'(k); coef_f1 = KW'(f1); coef_f2 = KW'(f2);
        @(posedge clk); #2;
        start = 1'b0;
        for (int i = 0; i < k; i++) begin
            in_valid = 1'b1; in_bit = ubits[i];
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        @(negedge clk);
        note(in_ready == 1'b0, "R2", "in_ready after K bits", int'(in_ready), 0);
        if (poke_start) begin
            repeat (20) @(negedge clk);
            @(posedge clk); #2;
            start = 1'b1; blk_len = KW'(40);
            @(posedge clk); #2;
            start = 1'b0;
            @(negedge clk);
            note(in_ready == 1'b0, "R9", "in_ready after start while busy", int'(in_ready), 0);
        end
        wait (blocks_done == target);
    endtask

    // Backpressure
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk); #2;
            out_ready = (($urandom % 4) != 0);
        end
    end

    // Scoreboard monitor
    initial begin
        bit   expect_done = 0;
        int   tail_seen = 0;
        bit   stalled = 0;
        logic [3:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (expect_done) begin
                    note(done === 1'b1, "R3", "done after last tail beat", int'(done), 1);
                    expect_done = 0;
                    blocks_done++;
                end else if (done !== 1'b0) begin
                    note(1'b0, "R3", "unexpected done", int'(done), 0);
                end
                if (stalled) begin
                    note(out_valid === 1'b1 &&
                         {out_tail, out_sys, out_par1, out_par2} === held,
                         "R8", "beat held under stall",
                         int'({out_valid, out_tail, out_sys, out_par1, out_par2}),
                         int'({1'b1, held}));
                end
                stalled = out_valid && !out_ready;
                held = {out_tail, out_sys, out_par1, out_par2};
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        note(1'b0, "R3", "beat with nothing expected", 1, 0);
                    end else begin
                        logic [3:0] e;
                        e = exp_q.pop_front();
                        if (e[3]) begin
                            note({out_tail, out_sys, out_par1, out_par2} === e, "R7",
                                 "tail beat", int'({out_tail, out_sys, out_par1, out_par2}),
                                 int'(e));
                            tail_seen++;
                            if (tail_seen == 4) begin
                                tail_seen = 0;
                                expect_done = 1;
                            end
                        end else begin
                            note(out_tail === 1'b0, "R3", "tail flag on data beat", int'(out_tail), 0);
                            note(out_sys === e[2], "R4", "systematic bit", int'(out_sys), int'(e[2]));
                            note(out_par1 === e[1], "R5", "natural parity", int'(out_par1), int'(e[1]));
                            note(out_par2 === e[0], "R6", "permuted parity", int'(out_par2), int'(e[0]));
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        note(1'b0, "WDOG", "run did not finish", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        note(in_ready === 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
        note(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        note(out_tail === 1'b0, "R1", "out_tail in reset", int'(out_tail), 0);
        note(done === 1'b0, "R1", "done in reset", int'(done), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        run_block(40, 3, 10, 1'b0);      // R10 smallest length
        run_block(512, 31, 64, 1'b1);    // R9 start while emitting
        run_block(1024, 31, 64, 1'b0);
        run_block(6144, 263, 480, 1'b0); // R10 largest length
        run_block(40, 3, 10, 1'b0);      // back-to-back reuse of state
        repeat (4) @(negedge clk);
        note(exp_q.size() == 0, "R3", "leftover expected beats", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule